// File: doc/BRIEF.md
# Request-Driven Single-Channel Byte Mover

This block is one channel of a transfer engine. It carries bytes between a memory bus and the data register of a peripheral. Each move starts when the peripheral pulses its request line. Software programs the peripheral address, the memory start address, the number of bytes, the direction, a 2-bit priority and two interrupt enables. It then sets the run bit. From then on, every accepted request becomes one beat: a read on the memory bus, followed by a write of that byte to the other side. After the beat the remaining count drops by one and the memory-side address steps forward by one. The peripheral-side address never changes.

Toward the peripheral the channel gives two strobes. One marks the final byte. The other fires one beat earlier, when the last-but-one byte lands, so the peripheral can prepare how it handles the final byte. The channel has two sticky flags, half-way and complete. Each flag drives its interrupt output only if that interrupt's enable bit is set.

Configuration uses a small select/write port with combinational read-back. Select 0 is the peripheral address, 1 the memory address, 2 the count, 3 control and 4 status.

Top module: `dma_chan`

## Requirements
- R1: Each request accepted while running with a nonzero count produces exactly one bus write, and the count read back (select 2) drops by exactly one per beat.
- R2: With control bit 1 set, the byte is read from the memory address and written to the peripheral address. With it clear, the byte is read from the peripheral address and written to the memory address.
- R3: After each beat the memory address (select 1) has increased by one, while the peripheral address (select 0) keeps its programmed value.
- R4: The beat that brings the count to zero causes a one-cycle pulse on per_eot in the cycle after its write is accepted, and sets status bit 1.
- R5: When the programmed count is two or more, per_eot_early pulses for one cycle after the last-but-one beat. It never pulses when the count is one and never coincides with per_eot.
- R6: Status bit 0 (half) becomes set on the beat after which the remaining count equals the programmed count shifted right by one.
- R7: irq_half is status bit 0 AND control bit 2. irq_done is status bit 1 AND control bit 3. Writing a 1 to a status bit through select 4 clears that bit.
- R8: While control bit 0 (run) is clear, requests are dropped and the bus stays idle. chan_prio always shows control bits 5:4.
- R9: Writes to selects 0, 1 and 2 have no effect while run is set or a beat is in flight.
- R10: Clearing run during a beat lets that beat finish and then stops the channel; later requests move nothing.
- R11: A request that arrives while a beat is in progress is held and served as the next beat.
- R12: Each beat reads first and then writes. bus_req, bus_we, bus_addr and bus_wdata are held steady until bus_ack.
- R13: After reset all registers and flags are zero and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Read-back of the selected register |
| per_req | input | 1 | Transfer request pulse from the peripheral |
| per_eot | output | 1 | Final-byte strobe |
| per_eot_early | output | 1 | Last-but-one byte strobe |
| bus_req | output | 1 | Memory bus access request |
| bus_we | output | 1 | Access is a write |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_rdata | input | DW | Read data, valid with bus_ack |
| bus_ack | input | 1 | Access accepted this cycle |
| irq_half | output | 1 | Half-way interrupt |
| irq_done | output | 1 | Complete interrupt |
| chan_prio | output | 2 | Programmed priority |

## Verification
The checker watches several rules on every cycle: bus signals held steady until accepted, a read always followed by a write, the count dropping by exactly one on each write acceptance, per_eot being a lone single-cycle pulse with the complete flag already set, and a quiet bus while the channel is stopped. Several behaviours can only be shown by the bench's scenarios. These are the byte values carried in each direction, the exact beat on which the early and final strobes and the half flag appear, the locking of configuration while running, merging of a request into the following beat, and an abort that lets the current beat finish.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

    typedef enum logic [1:0] {
        BT_IDLE  = 2'd0,
        BT_READ  = 2'd1,
        BT_WRITE = 2'd2
    } beat_state_t;

    // control word: bit0 run, bit1 to_periph, bit2 half_ie, bit3 done_ie, bits5:4 prio
    typedef struct packed {
        logic [1:0] prio;
        logic       done_ie;
        logic       half_ie;
        logic       to_periph;
        logic       run;
    } chan_ctrl_t;

    localparam int CTRL_W = 6;

    localparam logic [2:0] SEL_PADDR = 3'd0;
    localparam logic [2:0] SEL_MADDR = 3'd1;
    localparam logic [2:0] SEL_COUNT = 3'd2;
    localparam logic [2:0] SEL_CTRL  = 3'd3;
    localparam logic [2:0] SEL_STAT  = 3'd4;

    localparam int ST_HALF_BIT = 0;
    localparam int ST_DONE_BIT = 1;

    function automatic chan_ctrl_t ctrl_decode(input logic [CTRL_W-1:0] w);
        return chan_ctrl_t'(w);
    endfunction

endpackage

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 16,
    parameter int WW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [WW-1:0] cfg_wdata,
    output logic [WW-1:0] cfg_rdata,
    input  logic          busy,
    input  logic          beat_done,
    input  logic          half_set,
    input  logic          done_set,
    output chan_ctrl_t    ctrl_q,
    output logic [AW-1:0] paddr_q,
    output logic [AW-1:0] maddr_q,
    output logic [CW-1:0] cnt_rem,
    output logic [CW-1:0] cnt_init,
    output logic          half_flag,
    output logic          done_flag
);

    logic setup_ok;
    logic clr_half;
    logic clr_done;

    assign setup_ok = cfg_we && !ctrl_q.run && !busy;
    assign clr_half = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[ST_HALF_BIT];
    assign clr_done = cfg_we && (cfg_sel == SEL_STAT) && cfg_wdata[ST_DONE_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            paddr_q   <= '0;
            maddr_q   <= '0;
            cnt_rem   <= '0;
            cnt_init  <= '0;
            half_flag <= 1'b0;
            done_flag <= 1'b0;
        end else begin
            if (cfg_we && cfg_sel == SEL_CTRL)
                ctrl_q <= ctrl_decode(cfg_wdata[CTRL_W-1:0]);
            if (beat_done) begin
                maddr_q <= maddr_q + AW'(1);
                cnt_rem <= cnt_rem - CW'(1);
            end else if (setup_ok) begin
                case (cfg_sel)
                    SEL_PADDR: paddr_q <= cfg_wdata[AW-1:0];
                    SEL_MADDR: maddr_q <= cfg_wdata[AW-1:0];
                    SEL_COUNT: begin
                        cnt_rem  <= cfg_wdata[CW-1:0];
                        cnt_init <= cfg_wdata[CW-1:0];
                    end
                    default: ;
                endcase
            end
            half_flag <= (half_flag && !clr_half) || half_set;
            done_flag <= (done_flag && !clr_done) || done_set;
        end
    end

    always_comb begin
        cfg_rdata = '0;
        case (cfg_sel)
            SEL_PADDR: cfg_rdata[AW-1:0] = paddr_q;
            SEL_MADDR: cfg_rdata[AW-1:0] = maddr_q;
            SEL_COUNT: cfg_rdata[CW-1:0] = cnt_rem;
            SEL_CTRL:  cfg_rdata[CTRL_W-1:0] = ctrl_q;
            SEL_STAT: begin
                cfg_rdata[ST_HALF_BIT] = half_flag;
                cfg_rdata[ST_DONE_BIT] = done_flag;
            end
            default: cfg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/dma_chan_req.sv
module dma_chan_req (
    input  logic clk,
    input  logic rst,
    input  logic per_req,
    input  logic run,
    input  logic cnt_nz,
    input  logic take,
    output logic pend
);

    always_ff @(posedge clk) begin
        if (rst || !run)
            pend <= 1'b0;
        else
            pend <= (pend && !take) || (per_req && cnt_nz);
    end

endmodule

// File: rtl/dma_chan_beat.sv
module dma_chan_beat
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          go,
    input  logic          dir_in,
    input  logic [AW-1:0] paddr,
    input  logic [AW-1:0] maddr,
    input  logic          bus_ack,
    input  logic [DW-1:0] bus_rdata,
    output logic          take,
    output logic          busy,
    output logic          beat_done,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata
);

    beat_state_t   st;
    logic          dir_q;
    logic [DW-1:0] data_q;
    logic          mem_side;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= BT_IDLE;
            dir_q  <= 1'b0;
            data_q <= '0;
        end else begin
            case (st)
                BT_IDLE: if (go) begin
                    st    <= BT_READ;
                    dir_q <= dir_in;
                end
                BT_READ: if (bus_ack) begin
                    data_q <= bus_rdata;
                    st     <= BT_WRITE;
                end
                BT_WRITE: if (bus_ack) st <= BT_IDLE;
                default: st <= BT_IDLE;
            endcase
        end
    end

    always_comb begin
        take      = (st == BT_IDLE) && go;
        busy      = (st != BT_IDLE);
        bus_req   = (st == BT_READ) || (st == BT_WRITE);
        bus_we    = (st == BT_WRITE);
        mem_side  = (st == BT_READ) ? dir_q : !dir_q;
        bus_addr  = mem_side ? maddr : paddr;
        bus_wdata = data_q;
        beat_done = (st == BT_WRITE) && bus_ack;
    end

endmodule

// File: rtl/dma_chan_events.sv
module dma_chan_events #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          beat_done,
    input  logic [CW-1:0] cnt_rem,
    input  logic [CW-1:0] cnt_init,
    output logic          half_set,
    output logic          done_set,
    output logic          eot,
    output logic          eot_early
);

    localparam logic [CW-1:0] ONE = CW'(1);
    localparam logic [CW-1:0] TWO = CW'(2);

    logic [CW-1:0] half_mark;
    logic [CW-1:0] rem_after;

    assign half_mark = cnt_init >> 1;
    assign rem_after = cnt_rem - ONE;
    assign half_set  = beat_done && (rem_after == half_mark);
    assign done_set  = beat_done && (cnt_rem == ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            eot       <= 1'b0;
            eot_early <= 1'b0;
        end else begin
            eot       <= beat_done && (cnt_rem == ONE);
            eot_early <= beat_done && (cnt_rem == TWO);
        end
    end

endmodule

// File: rtl/dma_chan.sv
module dma_chan
    import dma_chan_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [2:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    output logic [31:0]   cfg_rdata,
    input  logic          per_req,
    output logic          per_eot,
    output logic          per_eot_early,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ack,
    output logic          irq_half,
    output logic          irq_done,
    output logic [1:0]    chan_prio
);

    localparam int WW = 32;

    chan_ctrl_t    ctrl_q;
    logic [AW-1:0] paddr_q;
    logic [AW-1:0] maddr_q;
    logic [CW-1:0] cnt_rem;
    logic [CW-1:0] cnt_init;
    logic          half_flag;
    logic          done_flag;
    logic          busy;
    logic          beat_done;
    logic          take;
    logic          pend;
    logic          go;
    logic          cnt_nz;
    logic          half_set;
    logic          done_set;
    logic          run_w;

    assign run_w  = ctrl_q.run;
    assign cnt_nz = (cnt_rem != '0);
    assign go     = pend && run_w && cnt_nz;

    dma_chan_regs #(.AW(AW), .CW(CW), .WW(WW)) u_regs (
        .clk       (clk),
        .rst       (rst),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .busy      (busy),
        .beat_done (beat_done),
        .half_set  (half_set),
        .done_set  (done_set),
        .ctrl_q    (ctrl_q),
        .paddr_q   (paddr_q),
        .maddr_q   (maddr_q),
        .cnt_rem   (cnt_rem),
        .cnt_init  (cnt_init),
        .half_flag (half_flag),
        .done_flag (done_flag)
    );

    dma_chan_req u_req (
        .clk     (clk),
        .rst     (rst),
        .per_req (per_req),
        .run     (run_w),
        .cnt_nz  (cnt_nz),
        .take    (take),
        .pend    (pend)
    );

    dma_chan_beat #(.AW(AW), .DW(DW)) u_beat (
        .clk       (clk),
        .rst       (rst),
        .go        (go),
        .dir_in    (ctrl_q.to_periph),
        .paddr     (paddr_q),
        .maddr     (maddr_q),
        .bus_ack   (bus_ack),
        .bus_rdata (bus_rdata),
        .take      (take),
        .busy      (busy),
        .beat_done (beat_done),
        .bus_req   (bus_req),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata)
    );

    dma_chan_events #(.CW(CW)) u_events (
        .clk       (clk),
        .rst       (rst),
        .beat_done (beat_done),
        .cnt_rem   (cnt_rem),
        .cnt_init  (cnt_init),
        .half_set  (half_set),
        .done_set  (done_set),
        .eot       (per_eot),
        .eot_early (per_eot_early)
    );

    assign irq_half  = half_flag && ctrl_q.half_ie;
    assign irq_done  = done_flag && ctrl_q.done_ie;
    assign chan_prio = ctrl_q.prio;

endmodule

// File: rtl/dma_chan_chk.sv
module dma_chan_chk #(
    parameter int AW = 32,
    parameter int DW = 8,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          bus_req,
    input logic          bus_ack,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic [DW-1:0] bus_wdata,
    input logic          per_eot,
    input logic          per_eot_early,
    input logic          done_flag,
    input logic [CW-1:0] cnt_rem,
    input logic          run
);

    // R12
    hold_until_ack_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) && $stable(bus_we) && $stable(bus_wdata)));

    // R12
    read_then_write_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && !bus_we) |=> (bus_req && bus_we));

    // R1
    count_step_chk: assert property (@(posedge clk) disable iff (rst)
        (bus_req && bus_ack && bus_we) |=> (cnt_rem == $past(cnt_rem) - CW'(1)));

    // R4
    eot_flag_chk: assert property (@(posedge clk) disable iff (rst)
        per_eot |-> done_flag);

    // R4
    eot_single_chk: assert property (@(posedge clk) disable iff (rst)
        per_eot |=> !per_eot);

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(per_eot && per_eot_early));

    // R8
    stopped_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!run && !bus_req) |=> !bus_req);

endmodule

bind dma_chan dma_chan_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
    .clk           (clk),
    .rst           (rst),
    .bus_req       (bus_req),
    .bus_ack       (bus_ack),
    .bus_we        (bus_we),
    .bus_addr      (bus_addr),
    .bus_wdata     (bus_wdata),
    .per_eot       (per_eot),
    .per_eot_early (per_eot_early),
    .done_flag     (done_flag),
    .cnt_rem       (cnt_rem),
    .run           (run_w)
);

// File: tb/dma_chan_bench.sv
`timescale 1ns/1ps
module dma_chan_bench;

    localparam int AW = 32;
    localparam int DW = 8;
    localparam logic [31:0] PA = 32'h0000_4000;
    localparam int VN = 5;
    // [31] to_periph, [30] half_ie, [29] done_ie, [23:16] base, [8] early expected, [7:0] count
    localparam logic [31:0] VECS [VN] = '{
        {1'b1, 1'b1, 1'b1, 5'd0, 8'h10, 7'd0, 1'b1, 8'd4},
        {1'b0, 1'b1, 1'b0, 5'd0, 8'h40, 7'd0, 1'b1, 8'd3},
        {1'b1, 1'b0, 1'b1, 5'd0, 8'h80, 7'd0, 1'b0, 8'd1},
        {1'b0, 1'b0, 1'b0, 5'd0, 8'hC0, 7'd0, 1'b1, 8'd6},
        {1'b0, 1'b1, 1'b1, 5'd0, 8'h20, 7'd0, 1'b1, 8'd2}
    };

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cfg_we = 1'b0;
    logic [2:0]    cfg_sel = 3'd0;
    logic [31:0]   cfg_wdata = '0;
    logic [31:0]   cfg_rdata;
    logic          per_req = 1'b0;
    logic          per_eot;
    logic          per_eot_early;
    logic          bus_req;
    logic          bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata;
    logic          bus_ack;
    logic          irq_half;
    logic          irq_done;
    logic [1:0]    chan_prio;

    logic          slow = 1'b0;
    logic [1:0]    wait_cnt;
    logic [7:0]    mem [256];
    logic [7:0]    per_log [64];
    logic [7:0]    per_src;
    int            per_wr_n;
    int            wr_n;
    int            eot_n, early_n, eot_at, early_at;
    int            total = 0;
    int            bad = 0;

    always #2.5 clk = ~clk;

    dma_chan u_dma_chan (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .per_req(per_req), .per_eot(per_eot), .per_eot_early(per_eot_early),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ack(bus_ack), .irq_half(irq_half), .irq_done(irq_done),
        .chan_prio(chan_prio)
    );

    assign bus_ack   = bus_req && (!slow || wait_cnt == 2'd2);
    assign bus_rdata = (bus_addr == PA) ? per_src : mem[bus_addr[7:0]];

    function automatic logic [7:0] init_val(input int a);
        return 8'((a * 7 + 3) & 255);
    endfunction

    always @(posedge clk) begin
        if (rst || !bus_req || bus_ack) wait_cnt <= 2'd0;
        else wait_cnt <= wait_cnt + 2'd1;
        if (rst) begin
            for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
            per_src  <= 8'h90;
            per_wr_n <= 0;
            wr_n     <= 0;
        end else if (bus_req && bus_ack) begin
            if (bus_we) begin
                wr_n <= wr_n + 1;
                if (bus_addr == PA) begin
                    per_log[per_wr_n[5:0]] <= bus_wdata;
                    per_wr_n <= per_wr_n + 1;
                end else begin
                    mem[bus_addr[7:0]] <= bus_wdata;
                end
            end else if (bus_addr == PA) begin
                per_src <= per_src + 8'd1;
            end
        end
    end

    always @(negedge clk) begin
        if (rst) begin
            eot_n = 0; early_n = 0; eot_at = 0; early_at = 0;
        end else begin
            if (per_eot) begin eot_n = eot_n + 1; eot_at = wr_n; end
            if (per_eot_early) begin early_n = early_n + 1; early_at = wr_n; end
        end
    end

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total = total + 1;
        if (got !== exp) begin
            bad = bad + 1;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic cfg_write(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_read(input logic [2:0] sel, output logic [31:0] d);
        @(negedge clk);
        cfg_sel = sel;
        #1 d = cfg_rdata;
    endtask

    task automatic pulse_req();
        @(negedge clk);
        per_req = 1'b1;
        @(negedge clk);
        per_req = 1'b0;
    endtask

    task automatic fire(input int n, input int gap);
        for (int i = 0; i < n; i++) begin
            pulse_req();
            wait_cycles(gap);
        end
    endtask

    task automatic setup(input logic to_p, input int n, input logic [7:0] base,
                         input logic hie, input logic die, input logic [1:0] prio);
        cfg_write(3'd3, 32'h0);
        cfg_write(3'd4, 32'h3);
        cfg_write(3'd0, PA);
        cfg_write(3'd1, {24'h0, base});
        cfg_write(3'd2, 32'(n));
        cfg_write(3'd3, {26'h0, prio, die, hie, to_p, 1'b1});
    endtask

    logic [31:0] rd;
    logic        v_dir, v_hie, v_die, v_early;
    logic [7:0]  v_base;
    int          v_n;
    int          wr0, eot0, early0, per0;
    logic [7:0]  src0;

    task automatic snap();
        wr0 = wr_n; eot0 = eot_n; early0 = early_n; per0 = per_wr_n; src0 = per_src;
    endtask

    initial begin
        fork
            begin
                wait_cycles(4);
                rst = 1'b0;
                wait_cycles(1);
                // R13 reset state
                check("R13 bus_req", 32'(bus_req), 0);
                check("R13 eot", 32'({per_eot, per_eot_early}), 0);
                check("R13 irq", 32'({irq_half, irq_done}), 0);
                cfg_read(3'd2, rd); check("R13 count", rd, 0);
                cfg_read(3'd3, rd); check("R13 ctrl", rd, 0);
                cfg_read(3'd4, rd); check("R13 status", rd, 0);

                // table of transfers: R1 R2 R3 R4 R5 R6 R7
                for (int k = 0; k < VN; k++) begin
                    v_dir = VECS[k][31]; v_hie = VECS[k][30]; v_die = VECS[k][29];
                    v_base = VECS[k][23:16]; v_early = VECS[k][8]; v_n = int'(VECS[k][7:0]);
                    setup(v_dir, v_n, v_base, v_hie, v_die, 2'(k));
                    snap();
                    fire(v_n, 6);
                    wait_cycles(4);
                    check("R1 writes", 32'(wr_n - wr0), 32'(v_n));
                    cfg_read(3'd2, rd); check("R1 count left", rd, 0);
                    cfg_read(3'd1, rd); check("R3 maddr", rd, 32'(v_base) + 32'(v_n));
                    cfg_read(3'd0, rd); check("R3 paddr", rd, PA);
                    for (int i = 0; i < v_n; i++) begin
                        if (v_dir) check("R2 to periph", 32'(per_log[(per0 + i) % 64]),
                                         32'(init_val(int'(v_base) + i)));
                        else check("R2 to memory", 32'(mem[8'(int'(v_base) + i)]), 32'(8'(src0 + 8'(i))));
                    end
                    check("R4 eot count", 32'(eot_n - eot0), 1);
                    check("R4 eot beat", 32'(eot_at), 32'(wr0 + v_n));
                    check("R5 early count", 32'(early_n - early0), 32'(v_early));
                    if (v_early) check("R5 early beat", 32'(early_at), 32'(wr0 + v_n - 1));
                    cfg_read(3'd4, rd); check("R4 R6 status", rd, 32'h3);
                    check("R7 irq_half", 32'(irq_half), 32'(v_hie));
                    check("R7 irq_done", 32'(irq_done), 32'(v_die));
                    check("R8 prio", 32'(chan_prio), 32'(k % 4));
                end

                // R8 requests dropped while stopped
                cfg_write(3'd3, 32'h0);
                cfg_write(3'd2, 32'd3);
                cfg_write(3'd3, 32'h20);
                snap();
                fire(2, 6);
                check("R8 no beats stopped", 32'(wr_n - wr0), 0);
                cfg_read(3'd2, rd); check("R8 count kept", rd, 3);
                check("R8 prio shown", 32'(chan_prio), 2);

                // R9 setup writes locked while running
                setup(1'b0, 2, 8'h50, 1'b0, 1'b0, 2'd0);
                cfg_write(3'd1, 32'h90);
                cfg_write(3'd2, 32'd9);
                cfg_read(3'd1, rd); check("R9 maddr locked", rd, 32'h50);
                cfg_read(3'd2, rd); check("R9 count locked", rd, 2);
                snap();
                fire(2, 6);
                check("R9 data at old addr", 32'(mem[8'h51]), 32'(8'(src0 + 8'd1)));
                check("R9 untouched", 32'(mem[8'h90]), 32'(init_val(8'h90)));

                // R6 half flag timing, R7 clear
                setup(1'b0, 5, 8'h60, 1'b1, 1'b0, 2'd0);
                fire(2, 6);
                cfg_read(3'd4, rd); check("R6 half not yet", rd, 0);
                check("R7 irq_half low", 32'(irq_half), 0);
                fire(1, 6);
                cfg_read(3'd4, rd); check("R6 half set", rd, 1);
                check("R7 irq_half high", 32'(irq_half), 1);
                cfg_write(3'd4, 32'h1);
                cfg_read(3'd4, rd); check("R7 half cleared", rd, 0);
                check("R7 irq_half cleared", 32'(irq_half), 0);
                fire(2, 6);
                cfg_read(3'd4, rd); check("R7 done only", rd, 2);

                // R11 back-to-back requests on a slow bus
                slow = 1'b1;
                setup(1'b0, 2, 8'h70, 1'b0, 1'b0, 2'd0);
                snap();
                pulse_req();
                pulse_req();
                wait_cycles(20);
                check("R11 both served", 32'(wr_n - wr0), 2);
                cfg_read(3'd2, rd); check("R11 count", rd, 0);
                check("R12 slow data", 32'(mem[8'h71]), 32'(8'(src0 + 8'd1)));

                // R10 abort during a beat
                setup(1'b0, 4, 8'h30, 1'b0, 1'b0, 2'd0);
                snap();
                pulse_req();
                wait_cycles(1);
                cfg_write(3'd3, 32'h0);
                wait_cycles(10);
                check("R10 beat finished", 32'(wr_n - wr0), 1);
                cfg_read(3'd2, rd); check("R10 count", rd, 3);
                fire(2, 6);
                check("R10 stopped", 32'(wr_n - wr0), 1);
                check("R10 no eot", 32'(eot_n - eot0), 0);
                slow = 1'b0;
            end
            begin
                #(5.0 * 150000);
                total = total + 1;
                bad = bad + 1;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule